// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand of a processor datapath. It takes a W-bit value and applies one of four shifts to it: logical left, logical right, arithmetic right or rotate right. Next to the shifted value it gives the shifter carry, which is the last bit shifted out. The flag logic that follows can take that carry as its C flag.

The shift amount comes from one of two sources. In immediate mode it is a small encoded field, and a zero in that field has its own meaning for each shift type. In register mode it is the low byte of a register, so it runs from 0 to 255, and amounts at or beyond the width follow their own rules. An optional output register stage adds one cycle of latency and helps timing. Its valid bit follows the input valid.

Top module: `operand_shifter`

## Requirements
- R1: Shift type encoding is 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For a nonzero amount n below W, the result is the value shifted or rotated by n.
- R2: For a nonzero amount n of at most W, carryOut is the last bit shifted out: input bit W-n for a left shift, and input bit n-1 for right shifts and rotates.
- R3: Immediate mode (regMode=0), logical left with immAmt=0: the result equals the input and carryOut equals carryIn.
- R4: Immediate mode, logical right with immAmt=0 acts as a shift by W: the result is all zeros and carryOut is input bit W-1.
- R5: Immediate mode, arithmetic right with immAmt=0 acts as a shift by W: every result bit and carryOut equal input bit W-1.
- R6: Immediate mode, rotate right with immAmt=0 is rotate-extended by one place: the result is {carryIn, input[W-1:1]} and carryOut is input bit 0.
- R7: Register mode (regMode=1) with regAmt=0, for every type: the result equals the input and carryOut equals carryIn.
- R8: Register mode logical shifts with regAmt of W or more give a zero result. At exactly W, carryOut is input bit 0 for a left shift and input bit W-1 for a right shift. Above W, carryOut is 0.
- R9: Register mode arithmetic right with regAmt of W or more fills the result with input bit W-1, and carryOut is input bit W-1.
- R10: Register mode rotate uses only the low log2(W) bits of regAmt. When those bits are zero but regAmt is nonzero, the result is unchanged and carryOut is input bit W-1.
- R11: With REG_OUT=1, result and carryOut show the operation from the previous cycle in which inValid was high. outValid is inValid delayed by one cycle. Reset clears outValid, result and carryOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operands are present this cycle |
| opValue | input | W | Value to shift |
| shiftType | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| regMode | input | 1 | 0 selects immAmt, 1 selects regAmt |
| immAmt | input | log2(W) | Encoded immediate shift amount |
| regAmt | input | 8 | Register-supplied shift amount, 0 to 255 |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | result and carryOut are valid |
| result | output | W | Shifted value |
| carryOut | output | 1 | Shifter carry |

## Verification
The bench goes after the points where an encoded or oversized amount changes the meaning of the shift. These are: immediate zero for each type; register amounts 0, 31, 32, 33 and 255; and rotate amounts whose low bits are zero. A design that treats an immediate zero as a plain zero shift would pass the value through for a right shift where zeros or sign bits belong, and would miss the rotate-extended form. A design that clamps register amounts the wrong way would give carry 1 for an amount of 33, or a zero result for a rotate by 32. A design that takes the carry from the wrong end would fail every nonzero amount of one of the types.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  localparam int AMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shKind_e;

  // Strobes from the amount decoder to the shift datapath
  typedef struct packed {
    logic             passThru;  // value and carry unchanged
    logic             rrx;       // one-place rotate through carry
    logic             zeroOut;   // result and carry forced to zero
    logic [AMT_W-1:0] amt;       // effective distance, 1..W
    shKind_e          kind;
  } shStrobe_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import opshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int REG_W = 8
) (
  input  logic [1:0]       shiftType,
  input  logic             regMode,
  input  logic [IMM_W-1:0] immAmt,
  input  logic [REG_W-1:0] regAmt,
  output shStrobe_t        strobe
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic [IMM_W-1:0] rotLow;
  assign rotLow = regAmt[IMM_W-1:0];

  always_comb begin
    strobe      = '0;
    strobe.kind = shKind_e'(shiftType);
    if (!regMode) begin
      if (immAmt == '0) begin
        unique case (strobe.kind)
          SH_LSL:         strobe.passThru = 1'b1;
          SH_LSR, SH_ASR: strobe.amt      = FULL;
          default:        strobe.rrx      = 1'b1;
        endcase
      end else begin
        strobe.amt = AMT_W'(immAmt);
      end
    end else if (regAmt == '0) begin
      strobe.passThru = 1'b1;
    end else begin
      unique case (strobe.kind)
        SH_LSL, SH_LSR: begin
          if (AMT_W'(regAmt) > FULL) strobe.zeroOut = 1'b1;
          else                       strobe.amt     = AMT_W'(regAmt);
        end
        SH_ASR: strobe.amt = (AMT_W'(regAmt) > FULL) ? FULL : AMT_W'(regAmt);
        default: strobe.amt = (rotLow == '0) ? FULL : AMT_W'(rotLow);
      endcase
    end
  end

endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import opshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opValue,
  input  logic         carryIn,
  input  shStrobe_t    strobe,
  output logic [W-1:0] shResult,
  output logic         shCarry
);

  logic [AMT_W-1:0] amtLess1;
  logic [AMT_W-1:0] amtComp;
  logic [W-1:0]     leftPre;
  logic [W-1:0]     rightPre;
  logic [W-1:0]     arithPre;
  logic [W-1:0]     leftOut;
  logic [W-1:0]     rightOut;
  logic [W-1:0]     arithOut;
  logic [W-1:0]     rotOut;

  assign amtLess1 = strobe.amt - AMT_W'(1);
  assign amtComp  = AMT_W'(W) - strobe.amt;

  // Shift by one place less to expose the last bit leaving the word
  assign leftPre  = opValue << amtLess1;
  assign rightPre = opValue >> amtLess1;
  assign arithPre = W'($signed(opValue) >>> amtLess1);

  assign leftOut  = opValue << strobe.amt;
  assign rightOut = opValue >> strobe.amt;
  assign arithOut = W'($signed(opValue) >>> strobe.amt);
  assign rotOut   = (opValue >> strobe.amt) | (opValue << amtComp);

  always_comb begin
    if (strobe.passThru) begin
      shResult = opValue;
      shCarry  = carryIn;
    end else if (strobe.rrx) begin
      shResult = {carryIn, opValue[W-1:1]};
      shCarry  = opValue[0];
    end else if (strobe.zeroOut) begin
      shResult = '0;
      shCarry  = 1'b0;
    end else begin
      unique case (strobe.kind)
        SH_LSL: begin
          shResult = leftOut;
          shCarry  = leftPre[W-1];
        end
        SH_LSR: begin
          shResult = rightOut;
          shCarry  = rightPre[0];
        end
        SH_ASR: begin
          shResult = arithOut;
          shCarry  = arithPre[0];
        end
        default: begin
          shResult = rotOut;
          shCarry  = rightPre[0];
        end
      endcase
    end
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int W       = 32,
  parameter int REG_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IMM_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [W-1:0]     opValue,
  input  logic [1:0]       shiftType,
  input  logic             regMode,
  input  logic [IMM_W-1:0] immAmt,
  input  logic [REG_W-1:0] regAmt,
  input  logic             carryIn,
  output logic             outValid,
  output logic [W-1:0]     result,
  output logic             carryOut
);

  shStrobe_t    strobe;
  logic [W-1:0] dpResult;
  logic         dpCarry;

  shift_ctrl #(.W(W), .IMM_W(IMM_W), .REG_W(REG_W)) u_ctrl (
    .shiftType (shiftType),
    .regMode   (regMode),
    .immAmt    (immAmt),
    .regAmt    (regAmt),
    .strobe    (strobe)
  );

  shift_dp #(.W(W)) u_dp (
    .opValue  (opValue),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .shResult (dpResult),
    .shCarry  (dpCarry)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          result   <= '0;
          carryOut <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            result   <= dpResult;
            carryOut <= dpCarry;
          end
        end
      end
    end else begin : g_comb
      assign outValid = inValid;
      assign result   = dpResult;
      assign carryOut = dpCarry;
    end
  endgenerate

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int W       = 32,
  parameter int REG_W   = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int IMM_W   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [W-1:0]     opValue,
  input logic [1:0]       shiftType,
  input logic             regMode,
  input logic [IMM_W-1:0] immAmt,
  input logic [REG_W-1:0] regAmt,
  input logic             carryIn,
  input logic [W-1:0]     dpResult,
  input logic             dpCarry,
  input logic             outValid,
  input logic [W-1:0]     result,
  input logic             carryOut
);

  a_r3_imm_lsl_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !regMode && shiftType == 2'b00 && immAmt == '0
      |-> dpResult == opValue && dpCarry == carryIn);

  a_r4_imm_lsr_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !regMode && shiftType == 2'b01 && immAmt == '0
      |-> dpResult == '0 && dpCarry == opValue[W-1]);

  a_r5_imm_asr_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !regMode && shiftType == 2'b10 && immAmt == '0
      |-> dpResult == {W{opValue[W-1]}} && dpCarry == opValue[W-1]);

  a_r6_imm_rrx: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !regMode && shiftType == 2'b11 && immAmt == '0
      |-> dpResult == {carryIn, opValue[W-1:1]} && dpCarry == opValue[0]);

  a_r7_reg_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regMode && regAmt == '0
      |-> dpResult == opValue && dpCarry == carryIn);

  a_r8_reg_logical_over: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regMode && !shiftType[1] && int'(regAmt) > W
      |-> dpResult == '0 && !dpCarry);

  a_r9_reg_asr_over: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regMode && shiftType == 2'b10 && int'(regAmt) >= W
      |-> dpResult == {W{opValue[W-1]}} && dpCarry == opValue[W-1]);

  a_r10_reg_rot_full: assert property (@(posedge clk) disable iff (!rstN)
    inValid && regMode && shiftType == 2'b11 && regAmt != '0
      && regAmt[IMM_W-1:0] == '0
      |-> dpResult == opValue && dpCarry == opValue[W-1]);

  generate
    if (REG_OUT) begin : g_pipe
      a_r11_capture: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid && result == $past(dpResult)
                    && carryOut == $past(dpCarry));
      a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
    end
  endgenerate

endmodule

bind operand_shifter operand_shifter_chk #(
  .W(W), .REG_W(REG_W), .REG_OUT(REG_OUT), .IMM_W(IMM_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opValue(opValue),
  .shiftType(shiftType), .regMode(regMode), .immAmt(immAmt),
  .regAmt(regAmt), .carryIn(carryIn), .dpResult(dpResult),
  .dpCarry(dpCarry), .outValid(outValid), .result(result),
  .carryOut(carryOut)
);

// File: tb/operand_shifter_bench.sv
`timescale 1ns/1ps
module operand_shifter_bench;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opValue = '0;
  logic [1:0]   shiftType = '0;
  logic         regMode = 1'b0;
  logic [4:0]   immAmt = '0;
  logic [7:0]   regAmt = '0;
  logic         carryIn = 1'b0;
  logic         outValid;
  logic [W-1:0] result;
  logic         carryOut;

  int    nTests = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  item_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  operand_shifter u_operand_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opValue(opValue),
    .shiftType(shiftType), .regMode(regMode), .immAmt(immAmt),
    .regAmt(regAmt), .carryIn(carryIn), .outValid(outValid),
    .result(result), .carryOut(carryOut)
  );

  // Reference: one place at a time, tracking the bit that leaves
  function automatic logic [W:0] refShift(input logic [W-1:0] v,
      input logic [1:0] t, input logic m, input logic [4:0] ia,
      input logic [7:0] ra, input logic cin);
    logic [W-1:0] x = v;
    logic         c = cin;
    int           n;
    if (!m) begin
      if (ia == 0) begin
        if (t == 2'b11) return {v[0], cin, v[W-1:1]};
        n = (t == 2'b00) ? 0 : W;
      end else n = ia;
    end else n = ra;
    for (int i = 0; i < n; i++) begin
      case (t)
        2'b00:   begin c = x[W-1]; x = {x[W-2:0], 1'b0}; end
        2'b01:   begin c = x[0];   x = {1'b0, x[W-1:1]}; end
        2'b10:   begin c = x[0];   x = {x[W-1], x[W-1:1]}; end
        default: begin c = x[0];   x = {x[0], x[W-1:1]}; end
      endcase
    end
    return {c, x};
  endfunction

  function automatic string tagFor(input logic [1:0] t, input logic m,
      input logic [4:0] ia, input logic [7:0] ra);
    if (!m) begin
      if (ia != 0) return "R1 R2";
      case (t)
        2'b00:   return "R3";
        2'b01:   return "R4";
        2'b10:   return "R5";
        default: return "R6";
      endcase
    end
    if (ra == 0) return "R7";
    if (t[1] == 1'b0 && ra >= W) return "R8";
    if (t == 2'b10 && ra >= W) return "R9";
    if (t == 2'b11 && ra[4:0] == 0) return "R10";
    return "R1 R2";
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [W:0] act, input logic [W:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual carry/result=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] v, input logic [1:0] t,
      input logic m, input logic [4:0] ia, input logic [7:0] ra,
      input logic cin);
    item_t      it;
    logic [W:0] e;
    @(negedge clk);
    inValid = 1'b1; opValue = v; shiftType = t; regMode = m;
    immAmt = ia; regAmt = ra; carryIn = cin;
    e = refShift(v, t, m, ia, ra, cin);
    it.res = e[W-1:0];
    it.cy  = e[W];
    it.tag = tagFor(t, m, ia, ra);
    expQ.push_back(it);
  endtask

  // Monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected outValid", {carryOut, result}, '0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(result == it.res && carryOut == it.cy, it.tag,
              {carryOut, result}, {it.cy, it.res});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    logic [W-1:0] pats[4] = '{32'h8000_0001, 32'h7FFF_FFFE,
                              32'hA5C3_0F96, 32'h0000_8000};
    repeat (3) @(negedge clk);
    // R11: reset state
    check(outValid == 1'b0 && result == '0 && carryOut == 1'b0,
          "R11 reset", {carryOut, result}, '0);
    rstN = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 6; a++)
          for (int p = 0; p < 4; p++)
            for (int c = 0; c < 2; c++)
              drive(pats[p], 2'(t), 1'(m), 5'(amts[a]),
                    m ? 8'(amts[a]) : 8'($urandom), 1'(c));
    for (int i = 0; i < 400; i++)
      drive($urandom, 2'($urandom), 1'($urandom), 5'($urandom),
            8'($urandom), 1'($urandom));
    // R10: rotate amounts with zero low bits
    for (int k = 1; k < 8; k++)
      drive(32'hC000_0003, 2'b11, 1'b1, 5'd0, 8'(k * 32), 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    // R11: every item consumed and output idle once input is idle
    check(expQ.size() == 0 && outValid == 1'b0, "R11 drain",
          {32'(expQ.size()), outValid}, '0);
    finish_run();
  end

endmodule